// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the bit-clock enable and the frame-sync pulse for a synchronous serial audio port when the port owns both the bit clock and the frame clock. A fixed divider turns the system clock into a one-cycle bit-clock enable. A frame counter advances on each enable. It raises the sync for a programmable number of bit clocks at the start of every frame and strobes a frame-start flag once per frame.

Frame length and pulse length are both written as the count minus one. For two 16-bit slots the period value is 31 and the width value is 15, which gives a sync that is active for half the frame. The bit-clock divider and the frame counter each have their own run enable, so the clock can run while the sync is held off. A polarity input chooses between an active-high and an active-low pin. When master mode is off, the block goes idle and passes an externally supplied sync straight to the output.

Top module: `fsync_gen`

## Requirements
- R1: While `master_i` and `gen_en_i` are both 1, `bclk_en_o` is high for exactly one clock in every `DIV` clocks (`DIV` = 4 by default). It first pulses in the `DIV`-th clock after the generator is enabled. Otherwise it is 0.
- R2: While the frame sync runs, `frame_start_o` pulses for one clock once every `period_m1_i + 1` bit-clock enables. Each pulse comes in the clock after the enable that begins the frame.
- R3: The sync is active for exactly `width_m1_i + 1` bit clocks, starting in the same clock as `frame_start_o`, and is inactive for the rest of the frame.
- R4: The sync is active only while `master_i`, `gen_en_i` and `fs_en_i` are all 1. With the clock running and `fs_en_i` at 0, the pin stays at its inactive level and `frame_start_o` stays 0.
- R5: With `fs_inv_i` = 0 the pin is active high, so its inactive level is 0. With `fs_inv_i` = 1 the pin is active low, so its inactive level is 1.
- R6: With `master_i` = 0, `fs_o` follows `fs_ext_i` in the same clock, and `bclk_en_o` and `frame_start_o` stay 0.
- R7: After `fs_en_i` is set, the first frame begins on the next bit-clock enable. The frame counter starts again from zero, whatever the state of any earlier run.
- R8: When either `gen_en_i` or `fs_en_i` is cleared, the counters clear. In master mode, `fs_o` is back at its inactive level one clock later.
- R9: While `rst_ni` is low, all state clears at once. `bclk_en_o` and `frame_start_o` are 0, and in master mode `fs_o` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate clock and sync; 0: bypass to external sync |
| gen_en_i | input | 1 | Run enable of the bit-clock divider (clock generator reset when 0) |
| fs_en_i | input | 1 | Run enable of the frame-sync counter (sync reset when 0) |
| period_m1_i | input | PER_W | Bit clocks per frame minus one |
| width_m1_i | input | PER_W | Sync pulse length in bit clocks minus one |
| fs_inv_i | input | 1 | 1 makes the sync active low |
| fs_ext_i | input | 1 | External frame sync used in bypass |
| bclk_en_o | output | 1 | One-cycle bit-clock enable |
| fs_o | output | 1 | Frame-sync pin |
| frame_start_o | output | 1 | One-cycle strobe at the start of each frame |

## Verification
The bench runs the standard two-slot setting across several full frames. It then switches to a one-bit-wide pulse with a six-bit period and an active-low pin. A design that miscounts the minus-one encoding would show a frame or pulse one bit clock too long or too short. Clearing `fs_en_i` or `gen_en_i` in the middle of a frame and then setting it again checks that the next frame starts from zero on the first enable. A design that kept the old count would resume partway through a frame. Bypass is driven with a toggling external sync, which catches a design that lets internal strobes leak out. An asynchronous reset in the middle of a frame catches a sync that stays stuck at its active level.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int unsigned DEF_DIV   = 4;
  localparam int unsigned DEF_PER_W = 8;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fsync_bclk_div.sv
module fsync_bclk_div #(
  parameter int unsigned DIV = fsync_pkg::DEF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = fsync_pkg::cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/fsync_timer.sv
module fsync_timer #(
  parameter int unsigned PER_W = fsync_pkg::DEF_PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_m1_i,
  input  logic [PER_W-1:0] width_m1_i,
  output logic             active_o,
  output logic             start_o
);
  logic             started_q;
  logic [PER_W-1:0] pos_q;
  logic [PER_W-1:0] pos_d;
  logic             active_q, start_q;

  // first tick after enable, or end of frame, restarts at slot zero
  always_comb begin
    if (!started_q || (pos_q >= period_m1_i)) pos_d = '0;
    else                                      pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      pos_q     <= '0;
      active_q  <= 1'b0;
      start_q   <= 1'b0;
    end else if (!run_i) begin
      started_q <= 1'b0;
      pos_q     <= '0;
      active_q  <= 1'b0;
      start_q   <= 1'b0;
    end else if (tick_i) begin
      started_q <= 1'b1;
      pos_q     <= pos_d;
      active_q  <= (pos_d <= width_m1_i);
      start_q   <= (pos_d == '0);
    end else begin
      start_q   <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign start_o  = start_q;
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int unsigned DIV   = fsync_pkg::DEF_DIV,
  parameter int unsigned PER_W = fsync_pkg::DEF_PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             gen_en_i,
  input  logic             fs_en_i,
  input  logic [PER_W-1:0] period_m1_i,
  input  logic [PER_W-1:0] width_m1_i,
  input  logic             fs_inv_i,
  input  logic             fs_ext_i,
  output logic             bclk_en_o,
  output logic             fs_o,
  output logic             frame_start_o
);
  logic gen_run, fs_run, tick, fs_act, fs_start;

  assign gen_run = master_i & gen_en_i;
  assign fs_run  = gen_run & fs_en_i;

  fsync_bclk_div #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (gen_run),
    .tick_o (tick)
  );

  fsync_timer #(.PER_W(PER_W)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (fs_run),
    .tick_i      (tick),
    .period_m1_i (period_m1_i),
    .width_m1_i  (width_m1_i),
    .active_o    (fs_act),
    .start_o     (fs_start)
  );

  assign bclk_en_o     = tick;
  assign frame_start_o = fs_start & master_i;
  assign fs_o          = master_i ? (fs_act ^ fs_inv_i) : fs_ext_i;
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic fs_en_i,
  input logic fs_inv_i,
  input logic bclk_en_o,
  input logic fs_o,
  input logic frame_start_o
);
  // R1: enable is a single-cycle pulse
  p_tick_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_en_o |=> !bclk_en_o);

  // R2: a frame start always follows a bit-clock enable
  p_start_after_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $past(bclk_en_o));

  // R3: the sync is active in the cycle a frame starts
  p_start_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && master_i) |-> (fs_o != fs_inv_i));

  // R6: bypass keeps the internal strobes quiet
  p_bypass_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!bclk_en_o && !frame_start_o));

  // R8: sync goes inactive one clock after its enable drops
  p_fs_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !fs_en_i) |=> (!master_i || fs_o == fs_inv_i));
endmodule

bind fsync_gen fsync_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .master_i      (master_i),
  .fs_en_i       (fs_en_i),
  .fs_inv_i      (fs_inv_i),
  .bclk_en_o     (bclk_en_o),
  .fs_o          (fs_o),
  .frame_start_o (frame_start_o)
);

// File: tb/sim_fsync_gen.sv
module sim_fsync_gen;
  localparam int CLK_P  = 10;
  localparam int DIV    = 4;
  localparam int PER_W  = 8;
  localparam int WD_CYC = 20000;

  typedef struct {
    logic  bclk;
    logic  fs;
    logic  fst;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master = 1'b0, gen_en = 1'b0, fs_en = 1'b0, fs_inv = 1'b0, fs_ext = 1'b0;
  logic [PER_W-1:0] per_m1 = 8'd31, wid_m1 = 8'd15;
  logic bclk_en, fs, fst;

  int n_chk = 0, n_fail = 0;
  exp_t sb[$];

  // bench-side expectation state
  int  m_div = 0, m_pos = 0;
  bit  m_started = 0, m_fs = 0, m_fst = 0;

  always #(CLK_P/2) clk = ~clk;

  fsync_gen #(.DIV(DIV), .PER_W(PER_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master), .gen_en_i(gen_en),
    .fs_en_i(fs_en), .period_m1_i(per_m1), .width_m1_i(wid_m1),
    .fs_inv_i(fs_inv), .fs_ext_i(fs_ext), .bclk_en_o(bclk_en),
    .fs_o(fs), .frame_start_o(fst)
  );

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (bclk_en !== e.bclk || fs !== e.fs || fst !== e.fst) begin
        n_fail++;
        $display("FAIL %s t=%0t: bclk/fs/start actual %b%b%b expected %b%b%b",
                 e.tag, $time, bclk_en, fs, fst, e.bclk, e.fs, e.fst);
      end
    end
  end

  // one clock: advance expectation per the requirements, queue the result
  task automatic step(input string tag);
    exp_t e;
    bit tick_now, grun;
    int np;
    @(posedge clk);
    #1;
    grun = gen_en && master;
    tick_now = grun && (m_div == DIV-1);
    if (!rst_ni) begin
      m_div = 0; m_started = 0; m_pos = 0; m_fs = 0; m_fst = 0;
    end else begin
      m_div = grun ? ((m_div == DIV-1) ? 0 : m_div + 1) : 0;
      if (!(grun && fs_en)) begin
        m_started = 0; m_pos = 0; m_fs = 0; m_fst = 0;
      end else if (tick_now) begin
        np = (!m_started || m_pos >= int'(per_m1)) ? 0 : m_pos + 1;
        m_started = 1; m_pos = np;
        m_fs  = (np <= int'(wid_m1));
        m_fst = (np == 0);
      end else begin
        m_fst = 0;
      end
    end
    e.bclk = rst_ni && grun && (m_div == DIV-1);
    e.fs   = master ? (m_fs ^ fs_inv) : fs_ext;
    e.fst  = m_fst && master;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    // R9: reset state
    run(3, "R9 reset");
    rst_ni = 1'b1;
    run(2, "R9 idle after reset");
    // R1, R4: clock runs, sync held off
    master = 1'b1; gen_en = 1'b1;
    run(24, "R1 R4 clock only");
    // R2, R3, R7: two-slot 16-bit frame
    fs_en = 1'b1;
    run(2*32*DIV + 40, "R2 R3 R7 period31 width15");
    // R5, R7: short frame, one-bit pulse, active low
    fs_en = 1'b0;
    run(3, "R8 fs_en drop");
    per_m1 = 8'd5; wid_m1 = 8'd0; fs_inv = 1'b1;
    run(2, "R5 inactive low-active");
    fs_en = 1'b1;
    run(6*DIV*3 + 5, "R5 R7 period5 width0 inv");
    // R8: generator reset mid-frame, then restart
    gen_en = 1'b0;
    run(3, "R8 gen_en drop");
    gen_en = 1'b1;
    run(6*DIV*2 + 7, "R7 R8 restart");
    // R6: bypass with toggling external sync
    master = 1'b0;
    for (int i = 0; i < 20; i++) begin
      fs_ext = i[1];
      step("R6 bypass");
    end
    // R9: asynchronous reset in the middle of a frame
    master = 1'b1; fs_inv = 1'b0; per_m1 = 8'd7; wid_m1 = 8'd3;
    run(DIV*5, "R3 period7 width3");
    rst_ni = 1'b0;
    #1;
    n_chk++;
    if (fs !== 1'b0 || bclk_en !== 1'b0 || fst !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 async clear: actual %b%b%b expected 000", bclk_en, fs, fst);
    end
    run(2, "R9 reset mid-run");
    rst_ni = 1'b1;
    run(DIV*8*2, "R7 R9 after reset");
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * WD_CYC);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule